// File: doc/BRIEF.md
# Dual-Channel Timer Compare Unit

This block watches the value of an external 8-bit timer/counter and compares it against two independently programmable compare values, channel A and channel B. When the counter equals a channel's compare value, the block raises a match signal for that channel. On the timer tick that follows, it latches a sticky per-channel flag and drives that channel's waveform pin according to a 2-bit pin action field. Each flag can be routed to an interrupt request. The flag is cleared either by an interrupt acknowledge or by a write-one-to-clear strobe.

The surrounding timer reports a two-bit waveform mode, the counting direction, and markers for top, bottom and the all-ones value.

- In the two non-PWM modes, a compare write takes effect at once.
- In the two PWM modes, a write lands in a shadow register. Fast PWM copies the shadow into the active compare value on the tick taken at bottom. Phase-correct PWM copies it on the tick taken at top. This keeps every PWM period whole and symmetric.
- In phase-correct mode, the pin action depends on direction. A match at the all-ones value always takes the up-count action.
- A per-channel force strobe applies the pin action without a match.
- In clear-on-compare mode, the channel A match is exported so the counter can restart.

Top module: `tcmp_unit`

## Requirements
- R1: After reset, both active compare values, both shadow registers, both flags, both interrupt requests and both pins are 0.
- R2: `match[i]` is 1 in any cycle where `cnt` equals channel i's active compare value, independent of `tick`.
- R3: A flag is set only by a clock edge at which `tick` is 1 and the channel matches. A match held without `tick` leaves the flag at 0.
- R4: `irq[i]` equals flag i AND `irq_en[i]`. A 1 on `irq_ack[i]` clears flag i at the next edge.
- R5: A 1 in bit i of `flag_clr` clears flag i at the next edge, and a 0 in that bit leaves the flag as it is. Setting by a match wins over any clear in the same cycle.
- R6: The waveform mode encoding is 00 normal, 01 clear-on-compare, 10 fast PWM and 11 phase-correct PWM. In modes 00 and 01, a write shows on the `cmp_a`/`cmp_b` output one cycle later.
- R7: In mode 10, a write changes the active compare value only at a tick edge where `at_bottom` is 1. In mode 11, this happens only at a tick edge where `at_top` is 1. At other edges the active value holds.
- R8: The pin action encoding is 00 keep, 01 toggle, 10 clear and 11 set. In modes 00, 01 and 10, the action is applied at the tick edge of a match.
- R9: In mode 11, action 10 clears the pin on an up-count match and sets it on a down-count match (`cnt_down`=1). Action 11 does the reverse.
- R10: In mode 11, a match while `at_max` is 1 takes the up-count action even when `cnt_down` is 1.
- R11: A 1 on `force_cmp[i]` applies channel i's up-count pin action at the next edge. It neither sets the flag nor raises an interrupt.
- R12: `ctr_clear` is 1 exactly when the mode is 01 and channel A matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable, one cycle per counter step |
| cnt | input | 8 | Live counter value |
| cnt_down | input | 1 | 1 while the counter counts down |
| at_top | input | 1 | Counter is at its top value |
| at_bottom | input | 1 | Counter is at zero |
| at_max | input | 1 | Counter is at all ones |
| wmode | input | 2 | Waveform mode (R6 encoding) |
| wr_en_a | input | 1 | Write strobe, channel A compare |
| wr_en_b | input | 1 | Write strobe, channel B compare |
| wr_data | input | 8 | Compare write data |
| pin_mode_a | input | 2 | Pin action, channel A |
| pin_mode_b | input | 2 | Pin action, channel B |
| irq_en | input | 2 | Interrupt enable per channel (bit 0 = A) |
| irq_ack | input | 2 | Interrupt acknowledge per channel |
| flag_clr | input | 2 | Write-one-to-clear flag strobe |
| force_cmp | input | 2 | Force pin action per channel |
| cmp_a | output | 8 | Active compare value, channel A |
| cmp_b | output | 8 | Active compare value, channel B |
| match | output | 2 | Equality per channel |
| flag | output | 2 | Sticky compare flags |
| irq | output | 2 | Interrupt requests |
| pin | output | 2 | Waveform pins (bit 0 = A) |
| ctr_clear | output | 1 | Counter restart request |

## Verification
The comparator is tested in three ways. A match held with `tick` low separates the combinational match from the tick-qualified flag. Two channels matching together show that flag clears act per bit. Counter values one off the compare value show that pins and flags stay put. Pin actions are stepped through all four codes in normal mode, then repeated in phase-correct mode with both directions and at the all-ones value, which shows whether direction and the MAX rule are honoured. The shadow register is tested with writes followed by plain ticks and then a tick at the correct boundary, which separates buffered loading from immediate loading.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    localparam int CNT_W_DEF = 8;
    localparam int NCH       = 2;

    typedef enum logic [1:0] {
        WM_NORMAL = 2'b00,
        WM_CTC    = 2'b01,
        WM_FAST   = 2'b10,
        WM_PHASE  = 2'b11
    } wave_mode_e;

    typedef enum logic [1:0] {
        PA_KEEP   = 2'b00,
        PA_TOGGLE = 2'b01,
        PA_CLEAR  = 2'b10,
        PA_SET    = 2'b11
    } pin_act_e;

    typedef struct packed {
        logic tick;
        logic down;
        logic at_top;
        logic at_bottom;
        logic at_max;
    } cnt_state_t;

    function automatic logic is_pwm(wave_mode_e m);
        return m[1];
    endfunction

    // Next pin level for an action; in phase-correct mode the direction
    // flips clear/set, except at the all-ones point, where the up action rules.
    function automatic logic next_pin(pin_act_e a, wave_mode_e m,
                                      logic down, logic at_max, logic cur);
        logic eff_down;
        eff_down = (m == WM_PHASE) && down && !at_max;
        case (a)
            PA_KEEP:   return cur;
            PA_TOGGLE: return ~cur;
            PA_CLEAR:  return eff_down;
            default:   return ~eff_down;
        endcase
    endfunction

endpackage

// File: rtl/tcmp_reg.sv
module tcmp_reg
    import tcmp_pkg::*;
#(
    parameter int CW = CNT_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  wave_mode_e    wmode,
    input  cnt_state_t    cs,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] active
);
    logic [CW-1:0] shadow;
    logic          load_pt;

    always_comb begin
        case (wmode)
            WM_FAST:  load_pt = cs.tick && cs.at_bottom;
            WM_PHASE: load_pt = cs.tick && cs.at_top;
            default:  load_pt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            active <= '0;
        end else begin
            if (wr_en)
                shadow <= wr_data;
            if (!is_pwm(wmode)) begin
                if (wr_en)
                    active <= wr_data;
            end else if (load_pt) begin
                active <= wr_en ? wr_data : shadow;
            end
        end
    end
endmodule

// File: rtl/tcmp_flag.sv
module tcmp_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr_sw,
    input  logic ack,
    input  logic ien,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set_ev)
            flag <= 1'b1;
        else if (clr_sw || ack)
            flag <= 1'b0;
    end

    assign irq = flag && ien;
endmodule

// File: rtl/tcmp_wave.sv
module tcmp_wave
    import tcmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ev_match,
    input  logic       ev_force,
    input  pin_act_e   act,
    input  wave_mode_e wmode,
    input  cnt_state_t cs,
    output logic       pin
);
    logic use_down;

    // A forced action without a real match uses the up-count action.
    assign use_down = ev_match ? cs.down : 1'b0;

    always_ff @(posedge clk) begin
        if (rst)
            pin <= 1'b0;
        else if (ev_match || ev_force)
            pin <= next_pin(act, wmode, use_down, cs.at_max && ev_match, pin);
    end
endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
    import tcmp_pkg::*;
#(
    parameter int CW = CNT_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [CW-1:0] cnt,
    input  logic          cnt_down,
    input  logic          at_top,
    input  logic          at_bottom,
    input  logic          at_max,
    input  logic [1:0]    wmode,
    input  logic          wr_en_a,
    input  logic          wr_en_b,
    input  logic [CW-1:0] wr_data,
    input  logic [1:0]    pin_mode_a,
    input  logic [1:0]    pin_mode_b,
    input  logic [1:0]    irq_en,
    input  logic [1:0]    irq_ack,
    input  logic [1:0]    flag_clr,
    input  logic [1:0]    force_cmp,
    output logic [CW-1:0] cmp_a,
    output logic [CW-1:0] cmp_b,
    output logic [1:0]    match,
    output logic [1:0]    flag,
    output logic [1:0]    irq,
    output logic [1:0]    pin,
    output logic          ctr_clear
);
    wave_mode_e    wm;
    cnt_state_t    cs;
    logic [CW-1:0] act_val [NCH];
    logic [NCH-1:0] wr_en_v;
    pin_act_e      pact    [NCH];

    assign wm         = wave_mode_e'(wmode);
    assign cs         = '{tick: tick, down: cnt_down, at_top: at_top,
                          at_bottom: at_bottom, at_max: at_max};
    assign wr_en_v    = {wr_en_b, wr_en_a};
    assign pact[0]    = pin_act_e'(pin_mode_a);
    assign pact[1]    = pin_act_e'(pin_mode_b);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic hit;
        assign hit       = (cnt == act_val[ch]);
        assign match[ch] = hit;

        tcmp_reg #(.CW(CW)) u_reg (
            .clk     (clk),
            .rst     (rst),
            .wmode   (wm),
            .cs      (cs),
            .wr_en   (wr_en_v[ch]),
            .wr_data (wr_data),
            .active  (act_val[ch])
        );

        tcmp_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_ev (tick && hit),
            .clr_sw (flag_clr[ch]),
            .ack    (irq_ack[ch]),
            .ien    (irq_en[ch]),
            .flag   (flag[ch]),
            .irq    (irq[ch])
        );

        tcmp_wave u_wave (
            .clk      (clk),
            .rst      (rst),
            .ev_match (tick && hit),
            .ev_force (force_cmp[ch]),
            .act      (pact[ch]),
            .wmode    (wm),
            .cs       (cs),
            .pin      (pin[ch])
        );
    end

    assign cmp_a     = act_val[0];
    assign cmp_b     = act_val[1];
    assign ctr_clear = (wm == WM_CTC) && match[0];
endmodule

// File: rtl/tcmp_unit_chk.sv
module tcmp_unit_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic [CW-1:0] cnt,
    input logic          at_top,
    input logic          at_bottom,
    input logic [1:0]    wmode,
    input logic          wr_en_a,
    input logic [CW-1:0] wr_data,
    input logic [1:0]    irq_ack,
    input logic [1:0]    flag_clr,
    input logic [1:0]    force_cmp,
    input logic [CW-1:0] cmp_a,
    input logic [1:0]    match,
    input logic [1:0]    flag,
    input logic          ctr_clear
);
    a_r3_flag_a_needs_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(flag[0]) |-> $past(tick && match[0]));
    a_r3_flag_b_needs_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(flag[1]) |-> $past(tick && match[1]));
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (irq_ack[0] && !(tick && match[0])) |=> !flag[0]);
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (flag_clr[1] && !(tick && match[1])) |=> !flag[1]);
    a_r6_direct_write: assert property (@(posedge clk) disable iff (rst)
        (!wmode[1] && wr_en_a) |=> (cmp_a == $past(wr_data)));
    a_r7_shadow_holds: assert property (@(posedge clk) disable iff (rst)
        (wmode[1] && !(tick && (at_top || at_bottom))) |=> $stable(cmp_a));
    a_r11_force_no_flag: assert property (@(posedge clk) disable iff (rst)
        (force_cmp[0] && !flag[0] && !(tick && match[0])) |=> !flag[0]);
    a_r12_clear_on_equal: assert property (@(posedge clk) disable iff (rst)
        ctr_clear |-> (cnt == cmp_a));
endmodule

bind tcmp_unit tcmp_unit_chk #(.CW(CW)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cnt       (cnt),
    .at_top    (at_top),
    .at_bottom (at_bottom),
    .wmode     (wmode),
    .wr_en_a   (wr_en_a),
    .wr_data   (wr_data),
    .irq_ack   (irq_ack),
    .flag_clr  (flag_clr),
    .force_cmp (force_cmp),
    .cmp_a     (cmp_a),
    .match     (match),
    .flag      (flag),
    .ctr_clear (ctr_clear)
);

// File: tb/test_tcmp_unit.sv
module test_tcmp_unit;
    logic       clk = 1'b0;
    logic       rst, tick, cnt_down, at_top, at_bottom, at_max;
    logic [7:0] cnt, wr_data, cmp_a, cmp_b;
    logic [1:0] wmode, pin_mode_a, pin_mode_b, irq_en, irq_ack, flag_clr, force_cmp;
    logic       wr_en_a, wr_en_b, ctr_clear;
    logic [1:0] match, flag, irq, pin;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;   // 50 MHz

    tcmp_unit i_tcmp_unit (
        .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .cnt_down(cnt_down),
        .at_top(at_top), .at_bottom(at_bottom), .at_max(at_max), .wmode(wmode),
        .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .wr_data(wr_data),
        .pin_mode_a(pin_mode_a), .pin_mode_b(pin_mode_b), .irq_en(irq_en),
        .irq_ack(irq_ack), .flag_clr(flag_clr), .force_cmp(force_cmp),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .match(match), .flag(flag), .irq(irq),
        .pin(pin), .ctr_clear(ctr_clear)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock edge, then return at the falling edge with strobes released
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        wr_en_a = 0; wr_en_b = 0; irq_ack = 0; flag_clr = 0; force_cmp = 0;
    endtask

    task automatic write_a(input logic [7:0] v);
        wr_en_a = 1; wr_data = v; step();
    endtask

    task automatic write_b(input logic [7:0] v);
        wr_en_b = 1; wr_data = v; step();
    endtask

    task automatic tick_at(input logic [7:0] v, input logic dn);
        cnt = v; cnt_down = dn; tick = 1; step(); tick = 0;
    endtask

    task automatic t_reset();
        rst = 1; tick = 0; cnt = 8'd7; cnt_down = 0; at_top = 0; at_bottom = 0;
        at_max = 0; wmode = 2'b00; wr_en_a = 0; wr_en_b = 0; wr_data = 0;
        pin_mode_a = 0; pin_mode_b = 0; irq_en = 0; irq_ack = 0; flag_clr = 0;
        force_cmp = 0;
        @(negedge clk); step(); step();
        rst = 0;
        check("R1 cmp_a", cmp_a, 0);
        check("R1 cmp_b", cmp_b, 0);
        check("R1 flag", flag, 0);
        check("R1 irq", irq, 0);
        check("R1 pin", pin, 0);
    endtask

    task automatic t_match_flag();
        write_a(8'd40);
        check("R6 immediate write", cmp_a, 40);
        write_b(8'd40);
        cnt = 8'd40; tick = 0;
        #1 check("R2 match without tick", match, 2'b11);
        step();
        check("R3 no flag without tick", flag, 0);
        tick_at(8'd40, 0);
        check("R3 flag after tick", flag, 2'b11);
        check("R8 keep action leaves pin", pin, 0);
        check("R4 irq masked", irq, 0);
        irq_en = 2'b01;
        #1 check("R4 irq enabled", irq, 2'b01);
        cnt = 8'd41;
        irq_ack = 2'b01; step();
        check("R4 ack clears A", flag, 2'b10);
        tick_at(8'd40, 0);
        flag_clr = 2'b00; step();
        check("R5 zero write no effect", flag, 2'b11);
        flag_clr = 2'b01; step();
        check("R5 w1c clears A only", flag, 2'b10);
        flag_clr = 2'b10; tick = 1; cnt = 8'd40; step(); tick = 0;
        check("R5 set wins over clear", flag, 2'b11);
        flag_clr = 2'b11; cnt = 8'd41; step();
        irq_en = 0;
    endtask

    task automatic t_pin_normal();
        pin_mode_a = 2'b01;
        tick_at(8'd40, 0);
        check("R8 toggle to 1", pin[0], 1);
        tick_at(8'd40, 0);
        check("R8 toggle to 0", pin[0], 0);
        pin_mode_a = 2'b11;
        tick_at(8'd41, 0);
        check("R8 no match no action", pin[0], 0);
        tick_at(8'd40, 0);
        check("R8 set", pin[0], 1);
        pin_mode_a = 2'b10;
        tick_at(8'd40, 0);
        check("R8 clear", pin[0], 0);
        flag_clr = 2'b11; cnt = 8'd0; step();
    endtask

    task automatic t_force();
        pin_mode_a = 2'b11; cnt = 8'd0;
        force_cmp = 2'b01; step();
        check("R11 force sets pin", pin[0], 1);
        check("R11 force no flag", flag, 0);
        check("R11 force no irq", irq, 0);
    endtask

    task automatic t_ctc();
        wmode = 2'b01; cnt = 8'd40;
        #1 check("R12 clear on A match", ctr_clear, 1);
        cnt = 8'd41;
        #1 check("R12 no clear off match", ctr_clear, 0);
        wmode = 2'b00; cnt = 8'd40;
        #1 check("R12 no clear in normal", ctr_clear, 0);
        cnt = 8'd0;
    endtask

    task automatic t_shadow();
        wmode = 2'b10; pin_mode_a = 2'b00;
        write_a(8'd100);
        check("R7 write buffered", cmp_a, 40);
        tick_at(8'd5, 0);
        check("R7 plain tick no load", cmp_a, 40);
        at_top = 1; tick_at(8'd5, 0); at_top = 0;
        check("R7 fast ignores top", cmp_a, 40);
        at_bottom = 1; tick_at(8'd0, 0); at_bottom = 0;
        check("R7 fast loads at bottom", cmp_a, 100);
        flag_clr = 2'b11; step();
    endtask

    task automatic t_phase();
        wmode = 2'b11;
        pin_mode_a = 2'b11; force_cmp = 2'b01; cnt = 8'd0; step();
        check("R11 force uses up action", pin[0], 1);
        pin_mode_a = 2'b10;
        tick_at(8'd100, 0);
        check("R9 up match clears", pin[0], 0);
        tick_at(8'd100, 1);
        check("R9 down match sets", pin[0], 1);
        pin_mode_a = 2'b11;
        tick_at(8'd100, 1);
        check("R9 inverse down clears", pin[0], 0);
        write_a(8'd255);
        at_bottom = 1; tick_at(8'd0, 1); at_bottom = 0;
        check("R7 phase ignores bottom", cmp_a, 100);
        at_top = 1; tick_at(8'd200, 0); at_top = 0;
        check("R7 phase loads at top", cmp_a, 255);
        tick_at(8'd255, 0);
        check("R9 set on up", pin[0], 1);
        pin_mode_a = 2'b10;
        at_max = 1; tick_at(8'd255, 1); at_max = 0;
        check("R10 max uses up action", pin[0], 0);
    endtask

    initial begin
        t_reset();
        t_match_flag();
        t_pin_normal();
        t_force();
        t_ctc();
        t_shadow();
        t_phase();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule